// File: doc/BRIEF.md
# USB Transceiver Control and Asynchronous Resume Wakeup

This block holds an 8-bit control and status register that sits beside a full-speed USB transceiver. Through it, software can fire a short, self-clearing hard reset into the USB core. It also sets a reserved configuration bit and arms an asynchronous resume wakeup. Three low bits report status: a clock-recovery event flag and a sync-detect flag, both supplied from outside, plus the latched wakeup event.

The wakeup path works without the USB clock. While the transceiver is suspended and the block runs as a device, a resume K-state on the raw, unfiltered D+/D− pins latches a wakeup level at once. The system uses this level to restart the USB clocks. The level stays latched until suspend is left or the enable is written to 0. The register itself runs on the system reset, so the configuration bits survive a USB hard reset.

Top module: `usb_xcvr_ctl`

## Requirements
- R1: After system reset, reg_rdata reads 8'h00 (with both status inputs low), usb_core_rst is 0 and wake_req is 0.
- R2: A register write with bit 7 set drives usb_core_rst high for exactly PULSE_LEN (default 2) clock cycles, starting with the cycle after the write edge.
- R3: Bit 7 of reg_rdata always reads 0, including during and after a hard reset request.
- R4: Bit 6 stores the written value and reads it back; its reset value is 0.
- R5: Bit 5 (wakeup enable) stores the written value. Bits 5 and 6 keep their values across a USB hard reset pulse.
- R6: Bits 4 and 3 always read 0. Writes to bits 2..0 have no effect. Bit 2 reflects clkrec_evt and bit 1 reflects syncdet_evt.
- R7: With bit 5 = 1, xcvr_suspend = 1, dev_mode = 1 and a K-state (line_dp = 0, line_dm = 1), wake_req goes high without waiting for a clock edge.
- R8: No wakeup is produced when the enable is 0, when dev_mode is 0, when not suspended, or when the line is in J (dp=1, dm=0) or SE0 (both 0).
- R9: Once set, wake_req stays high after the K-state ends. It clears when xcvr_suspend drops or when bit 5 is written to 0.
- R10: Bit 0 of reg_rdata mirrors wake_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System register clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| line_dp | input | 1 | Raw unfiltered D+ pin |
| line_dm | input | 1 | Raw unfiltered D− pin |
| xcvr_suspend | input | 1 | Transceiver is suspended |
| dev_mode | input | 1 | Controller is in device mode |
| clkrec_evt | input | 1 | Clock-recovery status flag from outside |
| syncdet_evt | input | 1 | Sync-detect status flag from outside |
| usb_core_rst | output | 1 | Hard reset to the USB core |
| wake_req | output | 1 | Latched asynchronous wakeup request |

## Verification
The assertions assume that no second hard-reset write arrives while a pulse is still running. They also assume that the line pins, suspend and mode flags are stable around the sampling clock edge, so the asynchronous latch has settled by the time they look at it. The bench meets both assumptions. It changes every input at the falling edge and waits out each reset pulse before the next access. It then sets the asynchronous wakeup conditions between edges, so it can see wake_req rise before any clock arrives.

// File: rtl/usb_xcvr_ctl.sv
module usb_xcvr_ctl #(
  parameter int PULSE_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       line_dp,
  input  logic       line_dm,
  input  logic       xcvr_suspend,
  input  logic       dev_mode,
  input  logic       clkrec_evt,
  input  logic       syncdet_evt,
  output logic       usb_core_rst,
  output logic       wake_req
);

  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic          wake_en;
  logic          cfg_bit6;
  logic [CW-1:0] rst_cnt;
  logic          k_state;
  logic          wake_set;
  logic          wake_clr_n;
  logic          wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en  <= 1'b0;
      cfg_bit6 <= 1'b0;
    end else if (reg_we) begin
      wake_en  <= reg_wdata[5];
      cfg_bit6 <= reg_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_cnt <= '0;
    else if (reg_we && reg_wdata[7])
      rst_cnt <= LOAD;
    else if (rst_cnt != '0)
      rst_cnt <= rst_cnt - 1'b1;
  end

  assign usb_core_rst = (rst_cnt != '0);

  assign k_state    = !line_dp && line_dm;
  assign wake_set   = wake_en && xcvr_suspend && dev_mode && k_state;
  assign wake_clr_n = rst_n && xcvr_suspend && wake_en;

  always_ff @(posedge wake_set or negedge wake_clr_n) begin
    if (!wake_clr_n)
      wake_q <= 1'b0;
    else
      wake_q <= 1'b1;
  end

  assign wake_req  = wake_q;
  assign reg_rdata = {1'b0, cfg_bit6, wake_en, 2'b00, clkrec_evt, syncdet_evt, wake_q};

  p_pulse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[7]) |=> usb_core_rst);

  p_pulse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_core_rst) |=> usb_core_rst);

  p_cfg_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(wake_en) && $stable(cfg_bit6)));

  p_no_wake_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_en || !xcvr_suspend) |-> !wake_req);

  p_wake_on_k_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && xcvr_suspend && dev_mode && !line_dp && line_dm) |-> wake_req);

  p_wake_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && xcvr_suspend && wake_en) |=> (wake_req || !xcvr_suspend || !wake_en));

endmodule

// File: tb/usb_xcvr_ctl_tb.sv
module usb_xcvr_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       line_dp = 1'b1, line_dm = 1'b0;
  logic       xcvr_suspend = 1'b0, dev_mode = 1'b1;
  logic       clkrec_evt = 1'b0, syncdet_evt = 1'b0;
  logic       usb_core_rst, wake_req;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  usb_xcvr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .line_dp(line_dp), .line_dm(line_dm),
    .xcvr_suspend(xcvr_suspend), .dev_mode(dev_mode),
    .clkrec_evt(clkrec_evt), .syncdet_evt(syncdet_evt),
    .usb_core_rst(usb_core_rst), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) reg_we = 1'b1; reg_wdata = d;
    @(negedge clk) reg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 core_rst", {7'd0, usb_core_rst}, 8'h00);
    chk("R1 wake", {7'd0, wake_req}, 8'h00);
  endtask

  task automatic t_hard_reset;
    wr(8'h60);
    chk("R4/R5 readback", reg_rdata, 8'h60);
    @(negedge clk) reg_we = 1'b1; reg_wdata = 8'h80;
    @(negedge clk) reg_we = 1'b0;
    chk("R2 cycle1", {7'd0, usb_core_rst}, 8'h01);
    chk("R3 bit7 during", {7'd0, reg_rdata[7]}, 8'h00);
    @(negedge clk);
    chk("R2 cycle2", {7'd0, usb_core_rst}, 8'h01);
    @(negedge clk);
    chk("R2 end", {7'd0, usb_core_rst}, 8'h00);
    chk("R3 bit7 after", {7'd0, reg_rdata[7]}, 8'h00);
    wr(8'hE0);
    repeat (3) @(negedge clk);
    chk("R5 kept across usb reset", reg_rdata, 8'h60);
  endtask

  task automatic t_fields;
    wr(8'h1F);
    chk("R6 low bits ignored", reg_rdata, 8'h00);
    chk("R4 bit6 cleared", {7'd0, reg_rdata[6]}, 8'h00);
    clkrec_evt = 1'b1;
    #1 chk("R6 clkrec bit2", reg_rdata, 8'h04);
    clkrec_evt = 1'b0; syncdet_evt = 1'b1;
    #1 chk("R6 syncdet bit1", reg_rdata, 8'h02);
    syncdet_evt = 1'b0;
  endtask

  task automatic t_wake_block;
    @(negedge clk) xcvr_suspend = 1'b1; line_dp = 1'b0; line_dm = 1'b1;
    #2 chk("R8 enable off", {7'd0, wake_req}, 8'h00);
    line_dp = 1'b1; line_dm = 1'b0;
    wr(8'h60);
    chk("R8 J state", {7'd0, wake_req}, 8'h00);
    line_dp = 1'b0; line_dm = 1'b0;
    #2 chk("R8 SE0", {7'd0, wake_req}, 8'h00);
    dev_mode = 1'b0; line_dm = 1'b1;
    #2 chk("R8 host mode", {7'd0, wake_req}, 8'h00);
    line_dm = 1'b0; dev_mode = 1'b1;
    @(negedge clk) xcvr_suspend = 1'b0; line_dm = 1'b1;
    #2 chk("R8 not suspended", {7'd0, wake_req}, 8'h00);
    line_dp = 1'b1; line_dm = 1'b0;
  endtask

  task automatic t_wake_set_clear;
    @(negedge clk) xcvr_suspend = 1'b1;
    #1 line_dp = 1'b0; line_dm = 1'b1;
    #1 chk("R7 async set", {7'd0, wake_req}, 8'h01);
    chk("R10 bit0 mirror", reg_rdata, 8'h61);
    @(negedge clk) line_dp = 1'b1; line_dm = 1'b0;
    @(negedge clk);
    chk("R9 latched after K", {7'd0, wake_req}, 8'h01);
    xcvr_suspend = 1'b0;
    #1 chk("R9 clear on resume", {7'd0, wake_req}, 8'h00);
    chk("R10 bit0 cleared", {7'd0, reg_rdata[0]}, 8'h00);
    @(negedge clk) xcvr_suspend = 1'b1; line_dp = 1'b0; line_dm = 1'b1;
    #1 chk("R7 set again", {7'd0, wake_req}, 8'h01);
    line_dp = 1'b1; line_dm = 1'b0;
    wr(8'h40);
    chk("R9 clear by enable write", {7'd0, wake_req}, 8'h00);
    @(negedge clk) xcvr_suspend = 1'b0;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hard_reset();
    t_fields();
    t_wake_block();
    t_wake_set_clear();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule